// File: doc/BRIEF.md
# Paged Slot Select Generator

This block maps a 64 KB processor address space onto four expansion slots in 16 KB pages. A byte-wide mapping register holds one 2-bit slot number for each page. During a memory access, the two most significant address bits pick a page. That page's field is looked up, and exactly one of four active-low slot-select lines is pulled low.

The block also produces three active-low chip selects for cartridges: one for the second page, one for the third page, and one that covers both. It decides whether the external cartridge data buffer may drive data toward the processor. The buffer is held off during I/O cycles and whenever slot 0 is addressed, because the main board serves those accesses itself.

The mapping register is written through a synchronous write port and can be read back at any time. Every decode output is combinational from the address, the bus strobes and the current register contents.

Top module: `slot_page_mapper`

## Requirements
- R1: A synchronous active-low reset clears the mapping register to 0x00, so every page selects slot 0. Reset takes priority over a write in the same cycle.
- R2: On a rising clock edge with `map_we` high, the register loads `map_wdata`, and `map_rdata` shows that value unchanged from then on. With `map_we` low, the register keeps its value whatever `map_wdata` carries.
- R3: The page index is address bits [15:14]. Page p uses register bits [2p+1:2p] as its slot number: bits [1:0] for 0x0000–0x3FFF, [3:2] for 0x4000–0x7FFF, [5:4] for 0x8000–0xBFFF and [7:6] for 0xC000–0xFFFF.
- R4: During an active memory cycle, exactly one bit of `slot_sel_n` is low, and its index equals the slot number chosen by R3.
- R5: An active memory cycle needs all three of the following: `mreq_n` low, `rfsh_n` high, and `rd_n` or `wr_n` low. Outside such a cycle every `slot_sel_n` bit is high, including refresh cycles and I/O cycles.
- R6: `cart_cs_lo_n` is low only during an active memory cycle addressing 0x4000–0x7FFF.
- R7: `cart_cs_hi_n` is low only during an active memory cycle addressing 0x8000–0xBFFF.
- R8: `cart_cs_span_n` is low only during an active memory cycle addressing 0x4000–0xBFFF.
- R9: `ext_rd_en` is high only in an active memory cycle in which all of the following hold: `rd_n` is low, `iorq_n` is high, and the selected slot is not 0. It is low in all other cases.
- R10: A register write affects the decode starting with the first address presented after the clock edge that performs it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the mapping register |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 16 | Processor address bus |
| mreq_n | input | 1 | Memory request, active low |
| rfsh_n | input | 1 | Refresh cycle marker, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| iorq_n | input | 1 | I/O request, active low |
| map_we | input | 1 | Mapping register write enable |
| map_wdata | input | 8 | Mapping register write data |
| map_rdata | output | 8 | Mapping register contents |
| slot_sel_n | output | 4 | Slot selects, one-hot active low |
| cart_cs_lo_n | output | 1 | Cartridge select for 0x4000–0x7FFF, active low |
| cart_cs_hi_n | output | 1 | Cartridge select for 0x8000–0xBFFF, active low |
| cart_cs_span_n | output | 1 | Cartridge select for 0x4000–0xBFFF, active low |
| ext_rd_en | output | 1 | Lets the cartridge buffer drive toward the processor |

## Verification
The bench builds the block with its default parameters: a 16-bit address, four pages and 2-bit slot numbers. The mapping register is therefore only 256 values wide, so every register value can be loaded through the write port. For each value, the bench sweeps every page at its first, last and one interior address, under seven bus-strobe patterns. These include refresh cycles, I/O cycles, a memory request with no strobe, and an illegal overlap of I/O and memory requests. Separate directed steps cover reset priority over a write, holding the value when writes are disabled, and the decode switching on the edge right after a write.

// File: rtl/slot_map_pkg.sv
// Shared defaults and the bus cycle classification for the slot mapper.
// Assumes a processor bus with active-low memory, refresh and strobe lines.
package slot_map_pkg;
    localparam int DEF_ADDR_W = 16;
    localparam int DEF_PAGE_W = 2;
    localparam int DEF_SLOT_W = 2;

    typedef enum logic [1:0] {
        CYC_IDLE    = 2'd0,
        CYC_MEM     = 2'd1,
        CYC_REFRESH = 2'd2
    } cyc_kind_e;
endpackage

// File: rtl/slot_map_reg.sv
// Mapping register: holds one slot field per page.
// Assumes synchronous active-low reset; reset wins over a write.
module slot_map_reg #(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] q
);
    // Load on write, clear on reset, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= wdata;
    end
endmodule

// File: rtl/page_slot_decode.sv
// Picks the page's slot field and drives a one-hot active-low slot select.
// Assumes the register packs page p's field at bits [p*SLOT_W +: SLOT_W].
module page_slot_decode #(
    parameter int PAGE_W = 2,
    parameter int SLOT_W = 2,
    localparam int NUM_PAGES = 1 << PAGE_W,
    localparam int NUM_SLOTS = 1 << SLOT_W,
    localparam int REG_W     = NUM_PAGES * SLOT_W
) (
    input  logic [REG_W-1:0]     map_q,
    input  logic [PAGE_W-1:0]    page,
    input  logic                 active,
    output logic [SLOT_W-1:0]    slot_num,
    output logic [NUM_SLOTS-1:0] slot_sel_n
);
    // Field selection by page index.
    always_comb begin
        slot_num = map_q[int'(page)*SLOT_W +: SLOT_W];
    end

    // One select line per slot, low only for the chosen slot.
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_sel
        assign slot_sel_n[s] = !(active && (slot_num == SLOT_W'(s)));
    end
endmodule

// File: rtl/cart_window_decode.sv
// Fixed-window cartridge chip selects, active low.
// Assumes the windows are whole pages: LO_PAGE, HI_PAGE and their union.
module cart_window_decode #(
    parameter int PAGE_W  = 2,
    parameter int LO_PAGE = 1,
    parameter int HI_PAGE = 2
) (
    input  logic [PAGE_W-1:0] page,
    input  logic              active,
    output logic              cs_lo_n,
    output logic              cs_hi_n,
    output logic              cs_span_n
);
    logic in_lo;
    logic in_hi;

    // Window membership and gating by the memory cycle.
    always_comb begin
        in_lo     = (page == PAGE_W'(LO_PAGE));
        in_hi     = (page == PAGE_W'(HI_PAGE));
        cs_lo_n   = !(active && in_lo);
        cs_hi_n   = !(active && in_hi);
        cs_span_n = !(active && (in_lo || in_hi));
    end
endmodule

// File: rtl/bus_dir_ctrl.sv
// Cartridge buffer direction: enables drive toward the processor only for
// reads from an external slot. Assumes slot 0 and I/O are on the main board.
module bus_dir_ctrl #(
    parameter int SLOT_W = 2
) (
    input  logic              active,
    input  logic              rd_n,
    input  logic              iorq_n,
    input  logic [SLOT_W-1:0] slot_num,
    output logic              ext_rd_en
);
    // External read enable.
    always_comb begin
        ext_rd_en = active && !rd_n && iorq_n && (slot_num != '0);
    end
endmodule

// File: rtl/slot_page_mapper.sv
// Top: paged slot select generator. Classifies the bus cycle, decodes the
// page's slot, the cartridge windows and the buffer direction.
// Assumes the page index is the top PAGE_W address bits.
module slot_page_mapper
    import slot_map_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int PAGE_W = DEF_PAGE_W,
    parameter int SLOT_W = DEF_SLOT_W,
    localparam int NUM_PAGES = 1 << PAGE_W,
    localparam int NUM_SLOTS = 1 << SLOT_W,
    localparam int REG_W     = NUM_PAGES * SLOT_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 mreq_n,
    input  logic                 rfsh_n,
    input  logic                 rd_n,
    input  logic                 wr_n,
    input  logic                 iorq_n,
    input  logic                 map_we,
    input  logic [REG_W-1:0]     map_wdata,
    output logic [REG_W-1:0]     map_rdata,
    output logic [NUM_SLOTS-1:0] slot_sel_n,
    output logic                 cart_cs_lo_n,
    output logic                 cart_cs_hi_n,
    output logic                 cart_cs_span_n,
    output logic                 ext_rd_en
);
    cyc_kind_e          cyc;
    logic               active;
    logic [PAGE_W-1:0]  page;
    logic [SLOT_W-1:0]  slot_num;
    logic               unused_low_addr;

    // Bus cycle classification from the strobes.
    always_comb begin
        if (mreq_n)                cyc = CYC_IDLE;
        else if (!rfsh_n)          cyc = CYC_REFRESH;
        else if (!rd_n || !wr_n)   cyc = CYC_MEM;
        else                       cyc = CYC_IDLE;
        active = (cyc == CYC_MEM);
    end

    assign page            = addr[ADDR_W-1 -: PAGE_W];
    assign unused_low_addr = ^addr[ADDR_W-PAGE_W-1:0];

    slot_map_reg #(.REG_W(REG_W)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (map_we),
        .wdata (map_wdata),
        .q     (map_rdata)
    );

    page_slot_decode #(.PAGE_W(PAGE_W), .SLOT_W(SLOT_W)) u_dec (
        .map_q      (map_rdata),
        .page       (page),
        .active     (active),
        .slot_num   (slot_num),
        .slot_sel_n (slot_sel_n)
    );

    cart_window_decode #(.PAGE_W(PAGE_W), .LO_PAGE(1), .HI_PAGE(2)) u_cart (
        .page      (page),
        .active    (active),
        .cs_lo_n   (cart_cs_lo_n),
        .cs_hi_n   (cart_cs_hi_n),
        .cs_span_n (cart_cs_span_n)
    );

    bus_dir_ctrl #(.SLOT_W(SLOT_W)) u_dir (
        .active    (active),
        .rd_n      (rd_n),
        .iorq_n    (iorq_n),
        .slot_num  (slot_num),
        .ext_rd_en (ext_rd_en)
    );
endmodule

// File: rtl/slot_map_checker.sv
// Property checker for slot_page_mapper, attached by bind below.
// Assumes the default packing of one SLOT_W field per page.
module slot_map_checker #(
    parameter int PAGE_W = 2,
    parameter int SLOT_W = 2,
    localparam int NUM_PAGES = 1 << PAGE_W,
    localparam int NUM_SLOTS = 1 << SLOT_W,
    localparam int REG_W     = NUM_PAGES * SLOT_W
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [PAGE_W-1:0]    page,
    input logic                 mreq_n,
    input logic                 rfsh_n,
    input logic                 rd_n,
    input logic                 wr_n,
    input logic                 iorq_n,
    input logic                 map_we,
    input logic [REG_W-1:0]     map_wdata,
    input logic [REG_W-1:0]     map_rdata,
    input logic [NUM_SLOTS-1:0] slot_sel_n,
    input logic                 cart_cs_lo_n,
    input logic                 cart_cs_hi_n,
    input logic                 cart_cs_span_n,
    input logic                 ext_rd_en
);
    logic mem_cyc;
    assign mem_cyc = !mreq_n && rfsh_n && (!rd_n || !wr_n);

    assert_write_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        map_we |=> (map_rdata == $past(map_wdata)));

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !map_we |=> $stable(map_rdata));

    assert_field_pick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cyc |-> !slot_sel_n[map_rdata[int'(page)*SLOT_W +: SLOT_W]]);

    assert_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cyc |-> ($countones(~slot_sel_n) == 1));

    assert_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cyc |-> (&slot_sel_n));

    assert_cs_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cyc |-> (cart_cs_lo_n && cart_cs_hi_n && cart_cs_span_n));

    assert_span_union_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cart_cs_span_n == (cart_cs_lo_n && cart_cs_hi_n));

    assert_buf_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!iorq_n || !slot_sel_n[0] || rd_n) |-> !ext_rd_en);
endmodule

bind slot_page_mapper slot_map_checker #(.PAGE_W(PAGE_W), .SLOT_W(SLOT_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .page           (addr[ADDR_W-1 -: PAGE_W]),
    .mreq_n         (mreq_n),
    .rfsh_n         (rfsh_n),
    .rd_n           (rd_n),
    .wr_n           (wr_n),
    .iorq_n         (iorq_n),
    .map_we         (map_we),
    .map_wdata      (map_wdata),
    .map_rdata      (map_rdata),
    .slot_sel_n     (slot_sel_n),
    .cart_cs_lo_n   (cart_cs_lo_n),
    .cart_cs_hi_n   (cart_cs_hi_n),
    .cart_cs_span_n (cart_cs_span_n),
    .ext_rd_en      (ext_rd_en)
);

// File: tb/tb_slot_page_mapper.sv
// Exhaustive sweep bench for slot_page_mapper at default parameters.
module tb_slot_page_mapper;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic        mreq_n = 1'b1, rfsh_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, iorq_n = 1'b1;
    logic        map_we = 1'b0;
    logic [7:0]  map_wdata = '0;
    logic [7:0]  map_rdata;
    logic [3:0]  slot_sel_n;
    logic        cart_cs_lo_n, cart_cs_hi_n, cart_cs_span_n, ext_rd_en;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    slot_page_mapper dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .mreq_n(mreq_n), .rfsh_n(rfsh_n),
        .rd_n(rd_n), .wr_n(wr_n), .iorq_n(iorq_n), .map_we(map_we),
        .map_wdata(map_wdata), .map_rdata(map_rdata), .slot_sel_n(slot_sel_n),
        .cart_cs_lo_n(cart_cs_lo_n), .cart_cs_hi_n(cart_cs_hi_n),
        .cart_cs_span_n(cart_cs_span_n), .ext_rd_en(ext_rd_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_map(input logic [7:0] v);
        @(negedge clk);
        map_we = 1'b1;
        map_wdata = v;
        @(posedge clk);
        #1;
        map_we = 1'b0;
        map_wdata = ~v;
        check("R2 load", map_rdata, v);
    endtask

    // Apply one bus pattern and compare all decode outputs.
    task automatic apply(input logic [7:0] regv, input logic [15:0] a,
                         input logic [4:0] ctl);
        logic act;
        int   pg, slot;
        {mreq_n, rfsh_n, rd_n, wr_n, iorq_n} = ctl;
        addr = a;
        #2;
        act  = !mreq_n && rfsh_n && (!rd_n || !wr_n);
        pg   = a >> 14;
        slot = (regv >> (2*pg)) & 3;
        check(act ? "R3 R4 slot" : "R5 idle", slot_sel_n,
              act ? (~(1 << slot)) & 4'hF : 4'hF);
        check("R6 cs_lo", cart_cs_lo_n, !(act && pg == 1));
        check("R7 cs_hi", cart_cs_hi_n, !(act && pg == 2));
        check("R8 cs_span", cart_cs_span_n, !(act && (pg == 1 || pg == 2)));
        check("R9 ext_rd_en", ext_rd_en, act && !rd_n && iorq_n && slot != 0);
    endtask

    // Bus patterns: {mreq_n, rfsh_n, rd_n, wr_n, iorq_n}
    function automatic logic [4:0] ctl_of(input int i);
        case (i)
            0: return 5'b01011; // memory read
            1: return 5'b01101; // memory write
            2: return 5'b11111; // idle
            3: return 5'b00011; // refresh with read low
            4: return 5'b11010; // I/O read
            5: return 5'b01111; // request without strobe
            default: return 5'b01010; // read with I/O overlap
        endcase
    endfunction

    initial begin : watchdog
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG && !done) begin
                fails++;
                checks++;
                $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
                $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        // R1: reset clears, and wins over a simultaneous write
        @(negedge clk);
        map_we = 1'b1;
        map_wdata = 8'hFF;
        repeat (2) @(posedge clk);
        #1;
        check("R1 reset value", map_rdata, 8'h00);
        @(negedge clk);
        map_we = 1'b0;
        rst_n = 1'b1;
        for (int p = 0; p < 4; p++) apply(8'h00, 16'(p << 14), ctl_of(0));

        // R2: value held while write enable is low
        write_map(8'hA5);
        @(negedge clk);
        map_wdata = 8'h3C;
        repeat (3) @(posedge clk);
        #1;
        check("R2 hold", map_rdata, 8'hA5);

        // R10: decode switches on the edge after the write
        write_map(8'h00);
        @(negedge clk);
        apply(8'h00, 16'h8123, ctl_of(0));
        map_we = 1'b1;
        map_wdata = 8'h30;
        @(posedge clk);
        #1;
        map_we = 1'b0;
        check("R10 new slot", slot_sel_n, 4'b0111);
        check("R10 ext_rd_en", ext_rd_en, 1);

        // Exhaustive sweep over register values, pages, offsets and patterns
        for (int v = 0; v < 256; v++) begin
            write_map(8'(v));
            for (int p = 0; p < 4; p++) begin
                for (int o = 0; o < 3; o++) begin
                    for (int c = 0; c < 7; c++) begin
                        apply(8'(v), 16'((p << 14) + (o == 0 ? 0 : (o == 1 ? 16'h3FFF : 16'h1234))),
                              ctl_of(c));
                    end
                end
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule